// File: doc/BRIEF.md
# Stereo CIC Decimation Filter

This block turns two single-bit oversampled streams, one for the left and one for the right channel, into wide signed samples at one thirty-second of the input sample rate. Each channel runs a fifth-order cascaded integrator-comb filter. The integrators run at the input sample rate and the combs run at the output rate. Both channels share one sample enable and one decimation counter, so their outputs always appear together under a single strobe.

The sample enable comes from the master clock through a divider. The divider ratio is chosen by a two-bit select, so one master clock frequency can serve designs whose modulator runs at the full clock rate or at half or a third of it. Each input bit counts as +1 when high and -1 when low. All internal state uses wrap-around two's complement arithmetic. The registers are wide enough that the comb outputs are exact even when the integrators wrap.

Top module: `stereo_cic_decim`

## Requirements
- R1: While rst_ni is low, and until the first strobe after its release, both sample outputs are 0 and valid_o is 0. Reset clears all filter state and restarts the decimation count, so the first valid_o after release comes exactly 32 enabled input samples later.
- R2: A high input bit counts as +1. A constant high input on a channel gives a steady output of +33554432, which is 32 to the fifth power. Reaching that value needs internal registers that wrap.
- R3: A low input bit counts as -1. A constant low input gives a steady output of -33554432.
- R4: The steady output equals (2p-1)·33554432, where p is the fraction of ones in an input pattern whose period divides 32. For example, pattern 1,1,1,0 gives 16777216 and pattern 1,0 gives 0. No output ever has a magnitude greater than 33554432.
- R5: The two channels are independent. A pattern on one input never changes the other channel's output.
- R6: div_sel_i sets the input sample rate. Code 0 enables every clock, code 1 every second clock, and codes 2 and 3 every third clock. The strobe period is therefore 32, 64 or 96 clocks.
- R7: valid_o is a single-cycle pulse. Exactly one pulse occurs for every 32 enabled input samples.
- R8: sample_l_o and sample_r_o change only in a cycle where valid_o is high. They hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| div_sel_i | input | 2 | input sample rate divider select |
| bit_l_i | input | 1 | left channel modulator bit |
| bit_r_i | input | 1 | right channel modulator bit |
| sample_l_o | output | 27 | left decimated sample, signed |
| sample_r_o | output | 27 | right decimated sample, signed |
| valid_o | output | 1 | one-cycle strobe for new samples |

## Verification
The hardest condition to reach is a full-scale steady state in which the last integrator has wrapped many times while the comb difference must still come out exact. The stimulus holds each input constant or periodic for hundreds of enables and then compares several consecutive outputs. By that point the integrators have wrapped repeatedly, so any width or sign-extension error would appear. Restarting the decimation count is reached by pulling reset in the middle of a full-scale run and counting clocks to the next strobe.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    DIV_BY_1 = 2'd0,
    DIV_BY_2 = 2'd1,
    DIV_BY_3 = 2'd2,
    DIV_ALT3 = 2'd3
  } div_sel_e;

  function automatic logic [1:0] div_ratio(input logic [1:0] sel);
    case (div_sel_e'(sel))
      DIV_BY_1: return 2'd1;
      DIV_BY_2: return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/cic_clk_en.sv
module cic_clk_en
  import cic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  output logic       en_o
);
  logic [1:0] cnt_q;
  logic [1:0] ratio;

  assign ratio = div_ratio(div_sel_i);
  assign en_o  = (cnt_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 2'd0;
    else if (cnt_q >= ratio - 2'd1) cnt_q <= 2'd0;
    else cnt_q <= cnt_q + 2'd1;
  end
endmodule

// File: rtl/cic_decim_ctrl.sv
module cic_decim_ctrl #(
  parameter int DECIM = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);

  logic [PH_W-1:0] phase_q;

  assign tick_o = en_i && (phase_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (en_i) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/cic_channel.sv
module cic_channel #(
  parameter int ORDER = 5,
  parameter int ACC_W = 27
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    tick_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] sample_o
);
  logic signed [ACC_W-1:0] integ_q [ORDER];
  logic signed [ACC_W-1:0] dly_q   [ORDER];
  logic signed [ACC_W-1:0] comb_d  [ORDER+1];
  logic signed [ACC_W-1:0] x_in;

  // bit 1 -> +1, bit 0 -> -1
  assign x_in = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar k = 0; k < ORDER; k++) begin : g_int
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) integ_q[k] <= '0;
        else if (en_i) integ_q[k] <= integ_q[k] + x_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) integ_q[k] <= '0;
        else if (en_i) integ_q[k] <= integ_q[k] + integ_q[k-1];
      end
    end
  end

  assign comb_d[0] = integ_q[ORDER-1];

  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign comb_d[k+1] = comb_d[k] - dly_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[k] <= '0;
      else if (tick_i) dly_q[k] <= comb_d[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else if (tick_i) sample_o <= comb_d[ORDER];
  end
endmodule

// File: rtl/stereo_cic_decim.sv
module stereo_cic_decim #(
  parameter int ORDER   = 5,
  parameter int DECIM   = 32,
  parameter int DECIM_W = $clog2(DECIM),
  parameter int ACC_W   = ORDER * DECIM_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              div_sel_i,
  input  logic                    bit_l_i,
  input  logic                    bit_r_i,
  output logic signed [ACC_W-1:0] sample_l_o,
  output logic signed [ACC_W-1:0] sample_r_o,
  output logic                    valid_o
);
  localparam int N_CH = 2;

  logic en;
  logic tick;
  logic [N_CH-1:0] bits;
  logic signed [ACC_W-1:0] samples [N_CH];

  assign bits = {bit_r_i, bit_l_i};

  cic_clk_en u_clk_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .en_o     (en)
  );

  cic_decim_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_o(tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cic_channel #(.ORDER(ORDER), .ACC_W(ACC_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en),
      .tick_i  (tick),
      .bit_i   (bits[c]),
      .sample_o(samples[c])
    );
  end

  assign sample_l_o = samples[0];
  assign sample_r_o = samples[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else valid_o <= tick;
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int ORDER = 5,
  parameter int DECIM = 32,
  parameter int ACC_W = 27
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    valid_i,
  input logic signed [ACC_W-1:0] sample_l_i,
  input logic signed [ACC_W-1:0] sample_r_i
);
  localparam int CNT_W = $clog2(DECIM) + 2;
  localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(DECIM ** ORDER);
  localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

  logic [CNT_W-1:0] en_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_cnt_q <= '0;
    else if (valid_i) en_cnt_q <= en_i ? CNT_W'(1) : '0;
    else if (en_i) en_cnt_q <= en_cnt_q + 1'b1;
  end

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_en_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> en_cnt_q == CNT_W'(DECIM));

  assert_hold_left_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_l_i) |-> valid_i);

  assert_hold_right_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_r_i) |-> valid_i);

  assert_range_left_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (sample_l_i <= FS_POS && sample_l_i >= FS_NEG));

  assert_range_right_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (sample_r_i <= FS_POS && sample_r_i >= FS_NEG));
endmodule

bind stereo_cic_decim cic_checker #(
  .ORDER(ORDER), .DECIM(DECIM), .ACC_W(ACC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en),
  .valid_i   (valid_o),
  .sample_l_i(sample_l_o),
  .sample_r_i(sample_r_o)
);

// File: tb/stereo_cic_decim_test.sv
module stereo_cic_decim_test;
  localparam int ACC_W = 27;
  localparam int FS    = 33554432;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic bit_l = 1'b0, bit_r = 1'b0;
  logic signed [ACC_W-1:0] s_l, s_r;
  logic valid;

  int checks = 0;
  int fails = 0;
  logic [31:0] pat_l = 32'hFFFF_FFFF, pat_r = 32'hFFFF_FFFF;
  int pat_len = 1;
  int idx = 0;

  always #5 clk = ~clk;

  stereo_cic_decim uut (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel),
    .bit_l_i(bit_l), .bit_r_i(bit_r),
    .sample_l_o(s_l), .sample_r_o(s_r), .valid_o(valid)
  );

  initial begin : driver
    forever begin
      @(negedge clk);
      bit_l <= pat_l[idx % pat_len];
      bit_r <= pat_r[idx % pat_len];
      idx = idx + 1;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_pat(input logic [31:0] l, input logic [31:0] r, input int len);
    pat_l = l; pat_r = r; pat_len = len; idx = 0;
  endtask

  task automatic settle_check(input string req, input longint exp_l, input longint exp_r);
    repeat (10) wait_valid();
    for (int i = 0; i < 3; i++) begin
      wait_valid();
      check(req, s_l, exp_l);
      check(req, s_r, exp_r);
    end
  endtask

  task automatic test_reset();
    set_pat(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    div_sel = 2'd0;
    do_reset();
    repeat (20) wait_valid();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 left in reset", s_l, 0);
    check("R1 right in reset", s_r, 0);
    check("R1 valid in reset", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!valid && n < 200);
      check("R1 first strobe clocks", n, 32);
    end
  endtask

  task automatic test_pos();
    set_pat(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    do_reset();
    settle_check("R2 full positive", FS, FS);
  endtask

  task automatic test_neg();
    set_pat(32'h0, 32'h0, 1);
    do_reset();
    settle_check("R3 full negative", -FS, -FS);
  endtask

  task automatic test_duty();
    set_pat(32'h7, 32'h1, 2);  // left 1,1 (len2 -> 1,1), right 1,0
    set_pat(32'h7, 32'h1, 4);  // left 1,1,1,0 ; right 1,0,0,0
    do_reset();
    settle_check("R4 duty patterns", FS / 2, -(FS / 2));
    set_pat(32'h1, 32'h2, 2);  // both alternating
    do_reset();
    settle_check("R4 alternating", 0, 0);
  endtask

  task automatic test_stereo();
    set_pat(32'hFFFF_FFFF, 32'h0, 1);
    do_reset();
    settle_check("R5 independent channels", FS, -FS);
  endtask

  task automatic test_ratio(input logic [1:0] sel, input int exp_period);
    int n;
    div_sel = sel;
    set_pat(32'hFFFF_FFFF, 32'h0, 1);
    do_reset();
    wait_valid();
    n = 0;
    do begin @(negedge clk); n++; end while (!valid && n < 400);
    check("R6 strobe period", n, exp_period);
    @(negedge clk);
    check("R7 single cycle strobe", valid, 0);
  endtask

  task automatic test_hold();
    logic signed [ACC_W-1:0] l0, r0;
    int bad = 0;
    set_pat(32'h7, 32'h1, 4);
    div_sel = 2'd1;
    do_reset();
    wait_valid();
    l0 = s_l; r0 = s_r;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!valid && (s_l != l0 || s_r != r0)) bad++;
    end
    check("R8 hold between strobes", bad, 0);
    div_sel = 2'd0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    check("R1 reset left", s_l, 0);
    check("R1 reset valid", valid, 0);
    test_reset();
    test_pos();
    test_neg();
    test_duty();
    test_stereo();
    test_ratio(2'd0, 32);
    test_ratio(2'd1, 64);
    test_ratio(2'd2, 96);
    test_ratio(2'd3, 96);
    div_sel = 2'd0;
    test_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule